// File: doc/BRIEF.md
# SPI FIFO Interrupt Status Controller

This block produces the single interrupt line of a SPI master that has transmit and receive FIFOs. It watches the FIFO occupancy counts and full flags, takes one-cycle event pulses for transmit underflow, receive overflow and mode fault, and keeps a seven-bit status word. Three of the status bits are sticky event flags. The other four are live level flags that are recomputed from the FIFO state on every clock. Two of the level flags compare a FIFO count with a programmable threshold.

Software reaches the block through a small single-cycle register port. It can read the status word, and that read clears it. It can clear single status bits by writing ones. It builds the interrupt mask through separate enable and disable registers, reads the mask back, and sets the two thresholds. While the master runs in its linear (memory-mapped) read mode, the automatic status updates are frozen. The interrupt output is registered.

Register addresses (`req_addr`): 0 status, 1 mask-enable, 2 mask-disable, 3 mask (read-only), 4 TX threshold, 5 RX threshold. Other addresses read as zero, and writes to them are ignored.

Top module: `spi_irq_status_ctrl`

## Requirements
- R1: Status bit 5 follows `rx_full` and status bit 3 follows `tx_full`. Both are recomputed one clock after the inputs change.
- R2: Status bit 4 is 1 exactly when `rx_count` is greater than or equal to the RX threshold.
- R3: Status bit 2 is 1 exactly when `tx_count` is strictly less than the TX threshold.
- R4: The event bits are bit 6 (`ev_tx_underflow`), bit 1 (`ev_mode_fault`) and bit 0 (`ev_rx_overflow`). Once an event pulse sets one of them, it stays set until software clears it.
- R5: A read of address 0 returns the status word and then clears all seven bits.
- R6: A write to address 0 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged.
- R7: A write to address 1 ORs write-data bits 6..0 into the mask. A write to address 2 clears those bits from the mask. Addresses 1 and 2 read as zero. Address 3 returns the mask, and a write to address 3 has no effect.
- R8: `irq` is the registered OR of (mask AND status). It rises one clock after the status bit and the mask bit are both set, and it falls one clock after the enabling condition goes away.
- R9: While `linear_mode` is 1, neither event pulses nor FIFO levels change the status word. Once `linear_mode` returns to 0, the live bits are recomputed.
- R10: After reset the status and the mask are zero, `irq` is 0, and both thresholds read back as 1.
- R11: If an event pulse and a clearing write to the same bit fall in the same cycle, the bit stays set.
- R12: A write to address 4 or 5 loads the low CNT_W write-data bits into the TX or RX threshold, and the value reads back at the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Register address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, valid in the same cycle as the read request |
| tx_count | input | CNT_W | TX FIFO occupancy |
| rx_count | input | CNT_W | RX FIFO occupancy |
| tx_full | input | 1 | TX FIFO full |
| rx_full | input | 1 | RX FIFO full |
| ev_tx_underflow | input | 1 | TX underflow event pulse |
| ev_rx_overflow | input | 1 | RX overflow event pulse |
| ev_mode_fault | input | 1 | Mode fault event pulse |
| linear_mode | input | 1 | Linear read mode active; freezes status updates |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that each register access is a single-cycle request and that, outside linear mode, an event pulse is taken in the same edge as any clear that lands with it. The bench keeps to this by driving every input on the falling edge and by holding each access valid for exactly one clock. Event pulses last one clock and are placed either clear of bus traffic or, for the priority case, deliberately on the same edge as a clearing write. The FIFO counts and thresholds are swept over their full range, and the expected level bits are computed arithmetically in the bench.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int IRQ_W = 7;

    localparam int B_TXUF   = 6;
    localparam int B_RXFULL = 5;
    localparam int B_RXNE   = 4;
    localparam int B_TXFULL = 3;
    localparam int B_TXNF   = 2;
    localparam int B_MODF   = 1;
    localparam int B_RXOVF  = 0;

    localparam logic [IRQ_W-1:0] STICKY_M = (IRQ_W'(1) << B_TXUF) |
                                            (IRQ_W'(1) << B_MODF) |
                                            (IRQ_W'(1) << B_RXOVF);
    localparam logic [IRQ_W-1:0] LIVE_M   = ~STICKY_M;

    typedef enum logic [2:0] {
        A_STATUS  = 3'd0,
        A_ENABLE  = 3'd1,
        A_DISABLE = 3'd2,
        A_MASK    = 3'd3,
        A_TXTHR   = 3'd4,
        A_RXTHR   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic rd_status;
        logic wr_status;
        logic wr_enable;
        logic wr_disable;
        logic wr_txthr;
        logic wr_rxthr;
    } strobe_t;

    function automatic logic [IRQ_W-1:0] pack_live(input logic rxf, input logic txf,
                                                   input logic rxne, input logic txnf);
        logic [IRQ_W-1:0] v;
        v = '0;
        v[B_RXFULL] = rxf;
        v[B_TXFULL] = txf;
        v[B_RXNE]   = rxne;
        v[B_TXNF]   = txnf;
        return v;
    endfunction

    function automatic logic [IRQ_W-1:0] pack_events(input logic uf, input logic modf,
                                                     input logic ovf);
        logic [IRQ_W-1:0] v;
        v = '0;
        v[B_TXUF]  = uf;
        v[B_MODF]  = modf;
        v[B_RXOVF] = ovf;
        return v;
    endfunction

endpackage

// File: rtl/spi_irq_regdec.sv
module spi_irq_regdec
    import spi_irq_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int DATA_W = 7
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_addr,
    input  logic [IRQ_W-1:0]  status_q,
    input  logic [IRQ_W-1:0]  mask_q,
    input  logic [CNT_W-1:0]  tx_thr,
    input  logic [CNT_W-1:0]  rx_thr,
    output strobe_t           strb,
    output logic [DATA_W-1:0] rdata
);

    logic is_rd;
    logic is_wr;

    assign is_rd = req_valid && !req_write;
    assign is_wr = req_valid && req_write;

    always_comb begin
        strb            = '0;
        strb.rd_status  = is_rd && (req_addr == A_STATUS);
        strb.wr_status  = is_wr && (req_addr == A_STATUS);
        strb.wr_enable  = is_wr && (req_addr == A_ENABLE);
        strb.wr_disable = is_wr && (req_addr == A_DISABLE);
        strb.wr_txthr   = is_wr && (req_addr == A_TXTHR);
        strb.wr_rxthr   = is_wr && (req_addr == A_RXTHR);
    end

    always_comb begin
        rdata = '0;
        if (is_rd) begin
            case (req_addr)
                A_STATUS: rdata = DATA_W'(status_q);
                A_MASK:   rdata = DATA_W'(mask_q);
                A_TXTHR:  rdata = DATA_W'(tx_thr);
                A_RXTHR:  rdata = DATA_W'(rx_thr);
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/spi_irq_thresh.sv
module spi_irq_thresh #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] thr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= CNT_W'(1);
        end else if (wr) begin
            thr_q <= wdata;
        end
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic [IRQ_W-1:0] clr_vec,
    input  logic [IRQ_W-1:0] ev_vec,
    input  logic [IRQ_W-1:0] live_vec,
    output logic [IRQ_W-1:0] status_q
);

    logic [IRQ_W-1:0] nxt;

    always_comb begin
        nxt = status_q & ~clr_vec;
        if (!freeze) begin
            nxt = (nxt & ~LIVE_M) | (live_vec & LIVE_M) | (ev_vec & STICKY_M);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
        end else begin
            status_q <= nxt;
        end
    end

endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic             clr_en,
    input  logic [IRQ_W-1:0] bits,
    input  logic [IRQ_W-1:0] status_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic             irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (set_en) begin
                mask_q <= mask_q | bits;
            end else if (clr_en) begin
                mask_q <= mask_q & ~bits;
            end
            irq <= |(mask_q & status_q);
        end
    end

endmodule

// File: rtl/spi_irq_status_ctrl.sv
module spi_irq_status_ctrl
    import spi_irq_pkg::*;
#(
    parameter  int CNT_W  = 6,
    localparam int DATA_W = (CNT_W > IRQ_W) ? CNT_W : IRQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [2:0]        req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic              tx_full,
    input  logic              rx_full,
    input  logic              ev_tx_underflow,
    input  logic              ev_rx_overflow,
    input  logic              ev_mode_fault,
    input  logic              linear_mode,
    output logic              irq
);

    strobe_t          strb;
    logic [IRQ_W-1:0] status_q;
    logic [IRQ_W-1:0] mask_q;
    logic [CNT_W-1:0] tx_thr;
    logic [CNT_W-1:0] rx_thr;
    logic [IRQ_W-1:0] clr_vec;
    logic [IRQ_W-1:0] ev_vec;
    logic [IRQ_W-1:0] live_vec;
    logic [IRQ_W-1:0] wbits;

    assign wbits = req_wdata[IRQ_W-1:0];

    spi_irq_regdec #(.CNT_W(CNT_W), .DATA_W(DATA_W)) regdec_i (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .tx_thr    (tx_thr),
        .rx_thr    (rx_thr),
        .strb      (strb),
        .rdata     (rsp_rdata)
    );

    spi_irq_thresh #(.CNT_W(CNT_W)) tx_thr_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (strb.wr_txthr),
        .wdata (req_wdata[CNT_W-1:0]),
        .thr_q (tx_thr)
    );

    spi_irq_thresh #(.CNT_W(CNT_W)) rx_thr_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (strb.wr_rxthr),
        .wdata (req_wdata[CNT_W-1:0]),
        .thr_q (rx_thr)
    );

    always_comb begin
        if (strb.rd_status) begin
            clr_vec = '1;
        end else if (strb.wr_status) begin
            clr_vec = wbits;
        end else begin
            clr_vec = '0;
        end
    end

    assign ev_vec   = pack_events(ev_tx_underflow, ev_mode_fault, ev_rx_overflow);
    assign live_vec = pack_live(rx_full, tx_full, (rx_count >= rx_thr), (tx_count < tx_thr));

    spi_irq_status status_i (
        .clk      (clk),
        .rst      (rst),
        .freeze   (linear_mode),
        .clr_vec  (clr_vec),
        .ev_vec   (ev_vec),
        .live_vec (live_vec),
        .status_q (status_q)
    );

    spi_irq_mask mask_i (
        .clk      (clk),
        .rst      (rst),
        .set_en   (strb.wr_enable),
        .clr_en   (strb.wr_disable),
        .bits     (wbits),
        .status_q (status_q),
        .mask_q   (mask_q),
        .irq      (irq)
    );

endmodule

// File: rtl/spi_irq_status_chk.sv
module spi_irq_status_chk
    import spi_irq_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             linear_mode,
    input logic             ev_tx_underflow,
    input logic             ev_rx_overflow,
    input logic [IRQ_W-1:0] status_q,
    input logic [IRQ_W-1:0] mask_q,
    input logic [IRQ_W-1:0] clr_vec,
    input strobe_t          strb,
    input logic             irq
);

    p_sticky_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (status_q[B_TXUF] && !clr_vec[B_TXUF]) |=> status_q[B_TXUF]);

    p_event_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_overflow && !linear_mode) |=> status_q[B_RXOVF]);

    p_underflow_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (ev_tx_underflow && !linear_mode) |=> status_q[B_TXUF]);

    p_linear_freeze_r9: assert property (@(posedge clk) disable iff (rst)
        (linear_mode && clr_vec == '0) |=> $stable(status_q));

    p_mask_ro_r7: assert property (@(posedge clk) disable iff (rst)
        (!strb.wr_enable && !strb.wr_disable) |=> $stable(mask_q));

    p_irq_rise_r8: assert property (@(posedge clk) disable iff (rst)
        (|(status_q & mask_q)) |=> irq);

    p_irq_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |=> !irq);

    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strb));

endmodule

bind spi_irq_status_ctrl spi_irq_status_chk chk_i (
    .clk             (clk),
    .rst             (rst),
    .linear_mode     (linear_mode),
    .ev_tx_underflow (ev_tx_underflow),
    .ev_rx_overflow  (ev_rx_overflow),
    .status_q        (status_q),
    .mask_q          (mask_q),
    .clr_vec         (clr_vec),
    .strb            (strb),
    .irq             (irq)
);

// File: tb/spi_irq_status_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_irq_status_ctrl_tb_top;

    localparam int CNT_W  = 6;
    localparam int DATA_W = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [2:0]        req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [DATA_W-1:0] rsp_rdata;
    logic [CNT_W-1:0]  tx_count = '0;
    logic [CNT_W-1:0]  rx_count = '0;
    logic              tx_full = 1'b0;
    logic              rx_full = 1'b0;
    logic              ev_tx_underflow = 1'b0;
    logic              ev_rx_overflow = 1'b0;
    logic              ev_mode_fault = 1'b0;
    logic              linear_mode = 1'b0;
    logic              irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    spi_irq_status_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk             (clk),
        .rst             (rst),
        .req_valid       (req_valid),
        .req_write       (req_write),
        .req_addr        (req_addr),
        .req_wdata       (req_wdata),
        .rsp_rdata       (rsp_rdata),
        .tx_count        (tx_count),
        .rx_count        (rx_count),
        .tx_full         (tx_full),
        .rx_full         (rx_full),
        .ev_tx_underflow (ev_tx_underflow),
        .ev_rx_overflow  (ev_rx_overflow),
        .ev_mode_fault   (ev_mode_fault),
        .linear_mode     (linear_mode),
        .irq             (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_read(input logic [2:0] a, output int d);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = a;
        #1;
        d = int'(rsp_rdata);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input int v);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_addr  = a;
        req_wdata = DATA_W'(v);
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic pulse(input int which);
        case (which)
            0: ev_rx_overflow = 1'b1;
            1: ev_mode_fault = 1'b1;
            default: ev_tx_underflow = 1'b1;
        endcase
        @(negedge clk);
        ev_rx_overflow  = 1'b0;
        ev_mode_fault   = 1'b0;
        ev_tx_underflow = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int d;
        int thr_list [4] = '{0, 1, 17, 63};
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        bus_read(3'd0, d); chk("R10 status", d, 0);
        chk("R10 irq", int'(irq), 0);
        bus_read(3'd3, d); chk("R10 mask", d, 0);
        bus_read(3'd4, d); chk("R10 txthr", d, 1);
        bus_read(3'd5, d); chk("R10 rxthr", d, 1);

        // R1 R2 R3 sweep of counts against thresholds
        foreach (thr_list[k]) begin
            bus_write(3'd4, thr_list[k]);
            bus_write(3'd5, thr_list[k]);
            for (int c = 0; c < 64; c++) begin
                int exp;
                tx_count = CNT_W'(c);
                rx_count = CNT_W'(c);
                rx_full  = c[0];
                tx_full  = c[1];
                idle(1);
                bus_read(3'd0, d);
                exp = (c[0] << 5) | ((c >= thr_list[k]) ? 16 : 0) |
                      (c[1] << 3) | ((c < thr_list[k]) ? 4 : 0);
                chk("R1 R2 R3 live bits", d & 8'h7C, exp);
            end
        end

        // quiet live bits
        bus_write(3'd4, 1);
        bus_write(3'd5, 1);
        tx_count = CNT_W'(1);
        rx_count = '0;
        rx_full  = 1'b0;
        tx_full  = 1'b0;
        idle(1);
        bus_read(3'd0, d); chk("R2 R3 quiet", d, 0);

        // R4 sticky events, R5 read clears
        for (int e = 0; e < 3; e++) begin
            int exp;
            exp = (e == 0) ? 8'h01 : (e == 1) ? 8'h02 : 8'h40;
            pulse(e);
            idle(3);
            bus_read(3'd0, d); chk("R4 sticky held", d, exp);
            bus_read(3'd0, d); chk("R5 read cleared", d, 0);
        end

        // R6 write-one-to-clear
        pulse(2);
        pulse(0);
        idle(1);
        bus_write(3'd0, 8'h40);
        bus_read(3'd0, d); chk("R6 w1c partial", d, 8'h01);

        // R11 event wins over same-cycle clear
        ev_rx_overflow = 1'b1;
        bus_write(3'd0, 8'h01);
        ev_rx_overflow = 1'b0;
        bus_read(3'd0, d); chk("R11 event wins", d, 8'h01);

        // R7 mask enable / disable / read-only
        bus_write(3'd1, 8'h41);
        bus_write(3'd2, 8'h01);
        bus_read(3'd3, d); chk("R7 mask built", d, 8'h40);
        bus_write(3'd3, 8'h7F);
        bus_read(3'd3, d); chk("R7 mask write ignored", d, 8'h40);
        bus_read(3'd1, d); chk("R7 enable reads 0", d, 0);
        bus_read(3'd2, d); chk("R7 disable reads 0", d, 0);

        // R8 irq timing
        chk("R8 irq idle", int'(irq), 0);
        ev_tx_underflow = 1'b1;
        @(negedge clk);
        ev_tx_underflow = 1'b0;
        chk("R8 irq one clock later", int'(irq), 0);
        @(negedge clk);
        chk("R8 irq raised", int'(irq), 1);
        bus_write(3'd2, 8'h40);
        chk("R8 irq still registered", int'(irq), 1);
        idle(1);
        chk("R8 irq dropped", int'(irq), 0);
        bus_read(3'd0, d); chk("R8 status kept", d, 8'h40);
        pulse(0);
        idle(3);
        chk("R8 masked event no irq", int'(irq), 0);
        bus_read(3'd0, d); chk("R4 overflow held", d, 8'h01);

        // R9 linear mode freezes status
        linear_mode = 1'b1;
        rx_full = 1'b1;
        pulse(0);
        idle(2);
        bus_read(3'd0, d); chk("R9 frozen", d, 0);
        linear_mode = 1'b0;
        idle(1);
        bus_read(3'd0, d); chk("R9 resumes live", d, 8'h20);
        rx_full = 1'b0;

        // R12 thresholds
        bus_write(3'd4, 8'h3F);
        bus_read(3'd4, d); chk("R12 txthr", d, 8'h3F);
        bus_write(3'd5, 8'h05);
        bus_read(3'd5, d); chk("R12 rxthr", d, 8'h05);
        bus_read(3'd4, d); chk("R12 txthr kept", d, 8'h3F);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule